// File: doc/BRIEF.md
# Power-Management Event Status and Wake Logic

This block keeps a 16-bit power-management status register and its enable register. Event inputs set the status bits. Software reads and clears them through a small register port. A status bit is cleared by writing a one to its position. Each status bit is combined with its own enable bit.

While the system is working, an enabled bit raises one of two interrupt levels. The SCI-enable input picks which one: SCI or SMI. While the system sleeps, the same enabled bits raise a wake request instead, and a wake-status bit is latched.

The block also watches the active-low power-button input. A press that lasts for a programmable number of prescaled ticks is an override. On an override the block drops the button status, records an override status and requests an unconditional shutdown.

Status bits live in three reset domains:
- The always-on reset clears only the override status.
- The resume reset clears the wake, alarm and button status.
- The core reset clears the remaining status bits, the enables and the button timer.

All register access is plain control: a write strobe, an address bit and write data. Read data is a combinational view of the addressed register. No stream interface is involved.

Top module: `pm_event_ctrl`

## Requirements
- R1: Writing the status register (`reg_addr`=0) with a 1 in a bit position clears that status bit, and a 0 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R2: `reg_rdata` shows the status register when `reg_addr`=0 and the enable register when `reg_addr`=1. Status bits exist at positions 0 (timer event), 5 (global event), 8 (button), 10 (alarm), 11 (override) and 15 (wake). Only enable bits 0, 5, 8 and 10 are writable (a write of 16'hFFFF reads back 16'h0521). All other bits read as zero and ignore writes.
- R3: `pwrbtn_n` passes through a two-flop synchronizer. A falling edge sets status bit 8 at the third rising clock edge after the input changes, whatever the enable bits hold.
- R4: When `in_sleep`=0, an enabled status bit among 0, 5, 8 and 10 drives `sci` if `sci_en`=1, and drives `smi` otherwise. Bit 5 never drives `smi`.
- R5: When `in_sleep`=1, `sci` and `smi` stay low. `wake_req` is high while bit 8 or bit 10 is set together with its enable. Bits 0 and 5 never cause a wake.
- R6: Status bit 15 is set at the clock edge that ends any cycle in which `wake_req` is high.
- R7: `rtc_alarm` sets status bit 10. The alarm produces `wake_req` only while enable bit 10 is 1.
- R8: After the synchronized button has been held for TICK_DIV*HOLD_TICKS consecutive cycles, one clock edge clears bit 8, sets bit 11 and raises `s5_req` for exactly one cycle. This happens once per press.
- R9: The core reset clears bits 0 and 5 and all enables. The resume reset clears bits 8, 10 and 15. Only the always-on reset clears bit 11.
- R10: `sci`, `smi` and `wake_req` are levels with no register stage. They follow status, enable, `sci_en` and `in_sleep` within the same cycle, and stay high while an enabled bit remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Always-on reset, active low, asynchronous |
| rst_rsm_n | input | 1 | Resume-domain reset, active low, asynchronous |
| rst_core_n | input | 1 | Core (soft) reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = enable |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| pwrbtn_n | input | 1 | Power button, active low, asynchronous |
| rtc_alarm | input | 1 | Alarm event, sets bit 10 |
| tmr_evt | input | 1 | Timer event, sets bit 0 |
| gbl_evt | input | 1 | Global event, sets bit 5 |
| sci_en | input | 1 | 1 routes working-state events to SCI, 0 to SMI |
| in_sleep | input | 1 | 1 while the system is in a sleeping state |
| sci | output | 1 | SCI level |
| smi | output | 1 | SMI level |
| wake_req | output | 1 | Wake request level |
| s5_req | output | 1 | One-cycle forced-shutdown request |

## Verification
Each result has a fixed timing:
- Event inputs and register writes show in `reg_rdata` one edge after they are driven.
- Interrupt and wake levels change in the same cycle as the status or enable bits they depend on.
- A button press reaches status at the third edge.
- The override lands TICK_DIV*HOLD_TICKS cycles after the synchronized press.

The bench drives inputs and checks outputs one time unit after the falling clock edge. Its reference model advances on each rising edge, so every comparison lands in the cycle where the result is due. Directed checks read the registers at the same point.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  localparam int REG_W = 16;

  // bit positions that the routing and the timer decode
  localparam int B_TMR = 0;
  localparam int B_GBL = 5;
  localparam int B_BTN = 8;
  localparam int B_RTC = 10;
  localparam int B_OVR = 11;
  localparam int B_WAK = 15;

  localparam logic [REG_W-1:0] STS_MASK  = 16'h8D21;
  localparam logic [REG_W-1:0] EN_MASK   = 16'h0521;
  localparam logic [REG_W-1:0] SCI_SRC   = 16'h0521;
  localparam logic [REG_W-1:0] SMI_SRC   = 16'h0501;
  localparam logic [REG_W-1:0] WAKE_SRC  = 16'h0500;

  // reset domains of the status bits
  localparam logic [REG_W-1:0] AON_DOM   = 16'h0800;
  localparam logic [REG_W-1:0] RSM_DOM   = 16'h8500;

  typedef enum logic {
    SEL_STS = 1'b0,
    SEL_EN  = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/pm_btn_timer.sv
module pm_btn_timer #(
  parameter int SYNC_STAGES = 2,
  parameter int TICK_DIV    = 32768,
  parameter int HOLD_TICKS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n_i,
  output logic held_o,
  output logic press_o,
  output logic fire_o
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_DIV - 1);
  localparam logic [HW-1:0] HOLD_LAST  = HW'(HOLD_TICKS - 1);
  localparam logic [HW-1:0] HOLD_SAT   = HW'(HOLD_TICKS);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   held_d_q;
  logic [PW-1:0]          presc_q;
  logic [HW-1:0]          hold_q;
  logic                   tick;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= btn_n_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_n_i};
      end
    end
  endgenerate

  assign held_o = ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_d_q <= 1'b0;
    else        held_d_q <= held_o;
  end

  assign press_o = held_o & ~held_d_q;

  // prescaler runs only while the button is held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     presc_q <= '0;
    else if (!held_o)               presc_q <= '0;
    else if (presc_q == PRESC_LAST) presc_q <= '0;
    else                            presc_q <= presc_q + 1'b1;
  end

  assign tick = held_o && (presc_q == PRESC_LAST);

  // tick counter saturates after the override so it fires once per press
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hold_q <= '0;
    else if (!held_o)                  hold_q <= '0;
    else if (tick && hold_q != HOLD_SAT) hold_q <= hold_q + 1'b1;
  end

  assign fire_o = tick && (hold_q == HOLD_LAST);

  a_r8_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
  a_r8_fire_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(held_o));
  a_r3_press_single: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o);

endmodule

// File: rtl/pm_sts_bank.sv
module pm_sts_bank
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_por_n,
  input  logic             rst_rsm_n,
  input  logic             rst_core_n,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] hw_clr_i,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] en_o,
  output logic [REG_W-1:0] rdata_o
);

  logic [REG_W-1:0] sw_clr;
  logic [REG_W-1:0] nxt_all;

  assign sw_clr  = (wr_i && sel_i == SEL_STS) ? wdata_i : '0;
  // a hardware set wins over any clear in the same cycle
  assign nxt_all = (sts_o & ~(sw_clr | hw_clr_i)) | set_i;

  generate
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (!STS_MASK[b]) begin : g_rsv
        assign sts_o[b] = nxt_all[b] & STS_MASK[b];
      end else if (AON_DOM[b]) begin : g_aon
        logic bit_q;
        always_ff @(posedge clk or negedge rst_por_n) begin
          if (!rst_por_n) bit_q <= 1'b0;
          else            bit_q <= nxt_all[b];
        end
        assign sts_o[b] = bit_q;
      end else if (RSM_DOM[b]) begin : g_rsm
        logic bit_q;
        always_ff @(posedge clk or negedge rst_rsm_n) begin
          if (!rst_rsm_n) bit_q <= 1'b0;
          else            bit_q <= nxt_all[b];
        end
        assign sts_o[b] = bit_q;
      end else begin : g_core
        logic bit_q;
        always_ff @(posedge clk or negedge rst_core_n) begin
          if (!rst_core_n) bit_q <= 1'b0;
          else             bit_q <= nxt_all[b];
        end
        assign sts_o[b] = bit_q;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)                  en_o <= '0;
    else if (wr_i && sel_i == SEL_EN) en_o <= wdata_i & EN_MASK;
  end

  assign rdata_o = (sel_i == SEL_EN) ? en_o : sts_o;

  a_r1_w1c_clears: assert property (@(posedge clk)
    disable iff (!rst_core_n || !rst_rsm_n || !rst_por_n)
    (wr_i && sel_i == SEL_STS && wdata_i[B_TMR] && !set_i[B_TMR]) |=> !sts_o[B_TMR]);
  a_r1_zero_keeps: assert property (@(posedge clk)
    disable iff (!rst_core_n || !rst_rsm_n || !rst_por_n)
    (wr_i && sel_i == SEL_STS && set_i == '0 && hw_clr_i == '0)
      |=> (sts_o == ($past(sts_o) & ~$past(wdata_i))));
  a_r1_set_wins: assert property (@(posedge clk)
    disable iff (!rst_core_n || !rst_rsm_n || !rst_por_n)
    set_i[B_GBL] |=> sts_o[B_GBL]);

endmodule

// File: rtl/pm_evt_route.sv
module pm_evt_route
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] sts_i,
  input  logic [REG_W-1:0] en_i,
  input  logic             sci_en_i,
  input  logic             in_sleep_i,
  output logic             sci_o,
  output logic             smi_o,
  output logic             wake_o
);

  logic [REG_W-1:0] live;
  logic any_sci, any_smi, any_wake;

  assign live     = sts_i & en_i;
  assign any_sci  = |(live & SCI_SRC);
  assign any_smi  = |(live & SMI_SRC);
  assign any_wake = |(live & WAKE_SRC);

  assign sci_o  = !in_sleep_i &&  sci_en_i && any_sci;
  assign smi_o  = !in_sleep_i && !sci_en_i && any_smi;
  assign wake_o =  in_sleep_i && any_wake;

  a_r4_sci_smi_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sci_o && smi_o));
  a_r5_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep_i |-> !(sci_o || smi_o));
  a_r4_gbl_no_smi: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_o && !sts_i[B_TMR] && !sts_i[B_BTN]) |-> (sts_i[B_RTC] && en_i[B_RTC]));

endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TICK_DIV    = 32768,
  parameter int HOLD_TICKS  = 4
) (
  input  logic        clk,
  input  logic        rst_por_n,
  input  logic        rst_rsm_n,
  input  logic        rst_core_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        pwrbtn_n,
  input  logic        rtc_alarm,
  input  logic        tmr_evt,
  input  logic        gbl_evt,
  input  logic        sci_en,
  input  logic        in_sleep,
  output logic        sci,
  output logic        smi,
  output logic        wake_req,
  output logic        s5_req
);

  logic             btn_held, btn_press, ovr_fire;
  logic [REG_W-1:0] set_vec, hw_clr_vec, sts, en;
  logic             s5_q;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(reg_addr);

  pm_btn_timer #(
    .SYNC_STAGES (SYNC_STAGES),
    .TICK_DIV    (TICK_DIV),
    .HOLD_TICKS  (HOLD_TICKS)
  ) u_btn (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .btn_n_i (pwrbtn_n),
    .held_o  (btn_held),
    .press_o (btn_press),
    .fire_o  (ovr_fire)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[B_TMR] = tmr_evt;
    set_vec[B_GBL] = gbl_evt;
    set_vec[B_BTN] = btn_press;
    set_vec[B_RTC] = rtc_alarm;
    set_vec[B_OVR] = ovr_fire;
    set_vec[B_WAK] = wake_req;
    hw_clr_vec        = '0;
    hw_clr_vec[B_BTN] = ovr_fire;
  end

  pm_sts_bank u_bank (
    .clk        (clk),
    .rst_por_n  (rst_por_n),
    .rst_rsm_n  (rst_rsm_n),
    .rst_core_n (rst_core_n),
    .wr_i       (reg_wr),
    .sel_i      (sel),
    .wdata_i    (reg_wdata),
    .set_i      (set_vec),
    .hw_clr_i   (hw_clr_vec),
    .sts_o      (sts),
    .en_o       (en),
    .rdata_o    (reg_rdata)
  );

  pm_evt_route u_route (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .sts_i      (sts),
    .en_i       (en),
    .sci_en_i   (sci_en),
    .in_sleep_i (in_sleep),
    .sci_o      (sci),
    .smi_o      (smi),
    .wake_o     (wake_req)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) s5_q <= 1'b0;
    else             s5_q <= ovr_fire;
  end
  assign s5_req = s5_q;

  a_r8_override_effect: assert property (@(posedge clk)
    disable iff (!rst_core_n || !rst_rsm_n || !rst_por_n)
    ovr_fire |=> (sts[B_OVR] && !sts[B_BTN] && s5_req));
  a_r8_s5_pulse: assert property (@(posedge clk)
    disable iff (!rst_core_n || !rst_rsm_n || !rst_por_n)
    s5_req |=> !s5_req);
  a_r6_wake_latch: assert property (@(posedge clk)
    disable iff (!rst_core_n || !rst_rsm_n || !rst_por_n)
    wake_req |=> sts[B_WAK]);
  a_r3_press_sets: assert property (@(posedge clk)
    disable iff (!rst_core_n || !rst_rsm_n || !rst_por_n)
    (btn_press && btn_held) |=> sts[B_BTN]);

endmodule

// File: tb/pm_event_ctrl_tb_top.sv
module pm_event_ctrl_tb_top;

  localparam int CLK_P   = 10;
  localparam int TB_DIV  = 4;
  localparam int TB_HOLD = 3;
  localparam int HOLD_N  = TB_DIV * TB_HOLD;

  logic        clk = 1'b0;
  logic        rst_por_n = 1'b0, rst_rsm_n = 1'b0, rst_core_n = 1'b0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pwrbtn_n = 1'b1, rtc_alarm = 1'b0, tmr_evt = 1'b0, gbl_evt = 1'b0;
  logic        sci_en = 1'b1, in_sleep = 1'b0;
  logic        sci, smi, wake_req, s5_req;

  int checks = 0;
  int fails  = 0;
  int s5_seen = 0;
  bit armed = 1'b0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pm_event_ctrl #(.TICK_DIV(TB_DIV), .HOLD_TICKS(TB_HOLD)) dut_i (
    .clk(clk), .rst_por_n(rst_por_n), .rst_rsm_n(rst_rsm_n), .rst_core_n(rst_core_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwrbtn_n(pwrbtn_n), .rtc_alarm(rtc_alarm), .tmr_evt(tmr_evt), .gbl_evt(gbl_evt),
    .sci_en(sci_en), .in_sleep(in_sleep), .sci(sci), .smi(smi), .wake_req(wake_req),
    .s5_req(s5_req)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [15:0] m_sts = '0, m_en = '0;
  logic        m_s0 = 1'b1, m_s1 = 1'b1, m_hd = 1'b0, m_s5 = 1'b0;
  int          m_cnt = 0;

  always @(posedge clk) begin : model
    logic held, press, fire, wk;
    logic [15:0] clr, setv, ns;
    held  = !m_s1;
    press = held && !m_hd;
    fire  = held && (m_cnt == HOLD_N - 1);
    wk    = in_sleep && ((m_sts[8] && m_en[8]) || (m_sts[10] && m_en[10]));
    clr   = (reg_wr && !reg_addr) ? reg_wdata : 16'h0;
    if (fire) clr[8] = 1'b1;
    setv = '0;
    setv[0] = tmr_evt; setv[5] = gbl_evt; setv[8] = press;
    setv[10] = rtc_alarm; setv[11] = fire; setv[15] = wk;
    ns = ((m_sts & ~clr) | setv) & 16'h8D21;
    if (reg_wr && reg_addr) m_en = reg_wdata & 16'h0521;
    m_sts = ns;
    m_cnt = held ? m_cnt + 1 : 0;
    m_hd  = held;
    m_s1  = m_s0;
    m_s0  = pwrbtn_n;
    m_s5  = fire;
    if (!rst_por_n) m_sts[11] = 1'b0;
    if (!rst_rsm_n) begin m_sts[15] = 1'b0; m_sts[10] = 1'b0; m_sts[8] = 1'b0; end
    if (!rst_core_n) begin
      m_sts[0] = 1'b0; m_sts[5] = 1'b0; m_en = '0;
      m_s0 = 1'b1; m_s1 = 1'b1; m_hd = 1'b0; m_cnt = 0; m_s5 = 1'b0;
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin : cmp
    logic [15:0] live;
    logic e_sci, e_smi, e_wk;
    if (s5_req === 1'b1) s5_seen++;
    if (armed && rst_por_n && rst_rsm_n && rst_core_n) begin
      live  = m_sts & m_en;
      e_sci = !in_sleep &&  sci_en && |(live & 16'h0521);
      e_smi = !in_sleep && !sci_en && |(live & 16'h0501);
      e_wk  =  in_sleep && |(live & 16'h0500);
      check("R1 R2 R9", "rdata", reg_rdata, reg_addr ? m_en : m_sts);
      check("R4 R10", "sci", sci, e_sci);
      check("R4 R10", "smi", smi, e_smi);
      check("R5 R7", "wake_req", wake_req, e_wk);
      check("R8", "s5_req", s5_req, m_s5);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] v;
    step(3);
    rst_por_n = 1'b1; rst_rsm_n = 1'b1; rst_core_n = 1'b1;
    armed = 1'b1;
    step();
    rd(0, v); check("R9", "status after reset", v, 16'h0000);
    rd(1, v); check("R9", "enable after reset", v, 16'h0000);

    // R2: register map and reserved bits
    wr(1, 16'hFFFF); rd(1, v); check("R2", "writable enables", v, 16'h0521);
    wr(0, 16'hFFFF); rd(0, v); check("R2", "status ignores reserved", v, 16'h0000);

    // R4/R1: timer event routing and write-one-to-clear
    sci_en = 1'b1; in_sleep = 1'b0;
    tmr_evt = 1'b1; step(); tmr_evt = 1'b0;
    rd(0, v); check("R4", "bit0 set", v, 16'h0001);
    check("R4", "sci from bit0", sci, 1'b1);
    sci_en = 1'b0; #1;
    check("R10", "smi follows sci_en", smi, 1'b1);
    check("R10", "sci drops", sci, 1'b0);
    wr(0, 16'h0000); rd(0, v); check("R1", "write zero keeps", v, 16'h0001);
    check("R10", "smi stays level", smi, 1'b1);
    wr(0, 16'h0001); rd(0, v); check("R1", "write one clears", v, 16'h0000);
    check("R1", "smi released", smi, 1'b0);

    // R4: bit 5 never raises SMI
    gbl_evt = 1'b1; step(); gbl_evt = 1'b0;
    rd(0, v); check("R4", "bit5 set", v, 16'h0020);
    check("R4", "bit5 no smi", smi, 1'b0);
    sci_en = 1'b1; #1; check("R4", "bit5 sci", sci, 1'b1);
    wr(0, 16'h0020);

    // R1: set wins over simultaneous clear
    tmr_evt = 1'b1; wr(0, 16'h0001); tmr_evt = 1'b0;
    rd(0, v); check("R1", "set beats clear", v, 16'h0001);
    wr(0, 16'h0001);

    // R3: press sets bit 8 at third edge, enables ignored
    wr(1, 16'h0000);
    pwrbtn_n = 1'b0; step(2);
    rd(0, v); check("R3", "not yet set", v, 16'h0000);
    step(); rd(0, v); check("R3", "button status set", v, 16'h0100);
    check("R3", "no sci while disabled", sci, 1'b0);
    pwrbtn_n = 1'b1; step(3);
    wr(1, 16'h0521); check("R10", "sci after enabling", sci, 1'b1);
    wr(0, 16'h0100); check("R1", "sci after clear", sci, 1'b0);

    // R5/R6: sleeping, button wakes and latches bit 15
    in_sleep = 1'b1;
    pwrbtn_n = 1'b0; step(3); pwrbtn_n = 1'b1;
    check("R5", "wake from button", wake_req, 1'b1);
    check("R5", "no sci in sleep", sci, 1'b0);
    step(); rd(0, v); check("R6", "wake status latched", v, 16'h8100);
    wr(0, 16'h0100); rd(0, v); check("R6", "wake status kept", v, 16'h8000);
    wr(0, 16'h8000); rd(0, v); check("R1", "wake status cleared", v, 16'h0000);
    step(2);

    // R5: bit 0 never wakes
    tmr_evt = 1'b1; step(); tmr_evt = 1'b0;
    check("R5", "bit0 no wake", wake_req, 1'b0);
    step(); rd(0, v); check("R5", "no wake status", v, 16'h0001);
    wr(0, 16'h0001);

    // R7: alarm wakes only when enabled
    wr(1, 16'h0121);
    rtc_alarm = 1'b1; step(); rtc_alarm = 1'b0;
    rd(0, v); check("R7", "alarm status", v, 16'h0400);
    check("R7", "no wake disabled", wake_req, 1'b0);
    step(); rd(0, v); check("R7", "still no wake status", v, 16'h0400);
    wr(1, 16'h0521); check("R7", "wake when enabled", wake_req, 1'b1);
    step(); rd(0, v); check("R6", "wake latched by alarm", v, 16'h8400);
    in_sleep = 1'b0; sci_en = 1'b1; #1;
    check("R4", "sci from alarm", sci, 1'b1);

    // R8: long hold
    s5_seen = 0;
    pwrbtn_n = 1'b0; step(HOLD_N + 6);
    rd(0, v); check("R8", "override status", v, 16'h8C00);
    check("R8", "s5 pulses", s5_seen, 1);
    step(10);
    check("R8", "single override per press", s5_seen, 1);
    pwrbtn_n = 1'b1; step(4);

    // R9: reset domains
    rst_core_n = 1'b0; step(); rst_core_n = 1'b1; step();
    rd(0, v); check("R9", "soft reset keeps", v, 16'h8C00);
    rd(1, v); check("R9", "soft reset clears enables", v, 16'h0000);
    rst_rsm_n = 1'b0; step(); rst_rsm_n = 1'b1; step();
    rd(0, v); check("R9", "resume reset keeps override", v, 16'h0800);
    rst_por_n = 1'b0; step(); rst_por_n = 1'b1; step();
    rd(0, v); check("R9", "always-on reset", v, 16'h0000);

    step(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule